// File: doc/BRIEF.md
# Column Command Timer with Latency Tracking

This block sits in the command path of a DRAM controller. It decides whether a pending column command (READ or WRITE) or a mode register set (MRS) may go out in the current cycle. When a command is allowed it raises `grant` combinationally. Otherwise it keeps `grant` low, and the requester holds the command until a later cycle. The gap between column commands depends on where they go. Back-to-back accesses to one bank group need the longer gap. Accesses that alternate between groups may use the shorter one. MRS commands have their own spacing, both to the next MRS and to the next column command.

For every accepted READ the block computes the read latency as CAS latency plus additive latency. It then produces a read-data-valid window of `BURST` cycles that opens that many cycles after acceptance. WRITEs work the same way, using CAS write latency plus additive latency, and drive a write-data-enable window. Both windows come from shift registers that are deep enough for the largest latency the configuration fields can encode. The configuration inputs are sampled into an internal active copy. That copy is refreshed only while no burst is pending and no column command is being accepted, so commands already in flight keep the latency they were issued with.

Top module: `col_cmd_timer`

## Requirements
- R1: A READ accepted in cycle n drives `rd_valid` high in cycles n+RL through n+RL+BURST-1 and low outside such windows, where RL = CL + AL from the active configuration (CL >= 1).
- R2: A WRITE accepted in cycle n drives `wr_en` high in cycles n+WL through n+WL+BURST-1, where WL = CWL + AL from the active configuration (CWL >= 1).
- R3: A column command to a different bank group than the previous column command is accepted no earlier than `ccd_s` cycles after that command.
- R4: A column command to the same bank group as the previous column command, whether a READ or a WRITE, is accepted no earlier than `ccd_l` cycles after it.
- R5: An MRS is accepted no earlier than `mrd` cycles after the previous MRS. It is not held back by column spacing.
- R6: A column command is accepted no earlier than `mod` cycles after the last MRS.
- R7: A request that breaks a spacing rule sees `grant` low and is granted in the first cycle in which every rule is met. It is never dropped.
- R8: Changes on the configuration inputs reach the active configuration only in a cycle with no pending data window and no accepted column command. A burst already pending keeps its original latency.
- R9: After reset `grant`, `rd_valid` and `wr_en` are low while no request is present. The configuration inputs are captured during reset, and the first column command and the first MRS face no spacing limit.
- R10: `req_kind` encodes 2'b01 READ, 2'b10 WRITE, 2'b11 MRS and 2'b00 deselect. A deselect is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A command is presented |
| req_kind | input | 2 | Command type: 01 READ, 10 WRITE, 11 MRS, 00 deselect |
| req_bg | input | BG_W | Bank group of the presented column command |
| cfg_cl | input | LAT_W | CAS latency |
| cfg_cwl | input | LAT_W | CAS write latency |
| cfg_al | input | LAT_W | Additive latency |
| cfg_ccd_s | input | SP_W | Column spacing across bank groups |
| cfg_ccd_l | input | SP_W | Column spacing within a bank group |
| cfg_mrd | input | SP_W | MRS-to-MRS spacing |
| cfg_mod | input | SP_W | MRS-to-column spacing |
| grant | output | 1 | The presented command is accepted this cycle |
| rd_valid | output | 1 | Read data window |
| wr_en | output | 1 | Write data window |

## Verification
The bench measures the exact cycle in which each held request is granted. Applying the short gap to a same-group pair, or the long gap across groups, therefore shows up as an early or late grant. It times MRS-to-MRS, MRS-to-READ and READ-to-MRS gaps separately. A design that shared one timer between these rules would either block MRS behind column spacing or let a READ through inside the MRS window. It changes CAS latency while a read is pending. A design that picked up the new value at once would move that pending burst, and one that never picked it up would leave the next read at the old latency. Every window is checked for its start cycle and its length, including with additive latency set to zero, which catches off-by-one errors in the latency shift register.

// File: rtl/cct_pkg.sv
// Package: shared command encoding for the column command timer.
// Assumes a two-bit command field on the request interface.
package cct_pkg;
    typedef enum logic [1:0] {
        CMD_DES = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_MRS = 2'b11
    } cmd_e;
endpackage

// File: rtl/cct_cfg_hold.sv
// Module: cct_cfg_hold
// Keeps the active copy of the latency and spacing settings. The copy
// follows the input vector in every cycle where hold is low, including
// during reset. Assumes hold covers every pending burst and every
// column command being accepted.
module cct_cfg_hold #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] act_o
);
    // Reload the active settings whenever the pipeline is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold) begin
            act_o <= cfg_i;
        end
    end

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(act_o));
endmodule

// File: rtl/cct_lat_line.sv
// Module: cct_lat_line
// Turns an accepted command into a BURST-cycle window that opens lat
// cycles later. Overlapping windows are merged by OR. Assumes lat >= 1
// and lat + BURST - 1 <= DEPTH.
module cct_lat_line #(
    parameter int LW    = 6,
    parameter int BURST = 4,
    parameter int DEPTH = 66
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [LW-1:0] lat,
    output logic          win,
    output logic          busy
);
    logic [DEPTH-1:0] sr;
    logic [DEPTH-1:0] mask;

    // Mark the slots that reach the output lat..lat+BURST-1 cycles from now.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mask[i] = issue && ((i + 1) >= int'(lat)) && ((i + 1) < int'(lat) + BURST);
        end
    end

    // Advance pending windows one slot per cycle and merge new ones in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= (sr >> 1) | mask;
        end
    end

    assign win  = sr[0];
    assign busy = |sr;

    p_lat_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (lat != '0));
    p_issue_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> busy);
endmodule

// File: rtl/cct_spacing.sv
// Module: cct_spacing
// Tracks the cycles since the last column command and the last MRS and
// reports whether a new column command or MRS may go out. Counters
// saturate at their maximum, which is never below any configured gap.
module cct_spacing #(
    parameter int BG_W = 2,
    parameter int SP_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            col_fire,
    input  logic            mrs_fire,
    input  logic [BG_W-1:0] req_bg,
    input  logic [SP_W-1:0] ccd_s,
    input  logic [SP_W-1:0] ccd_l,
    input  logic [SP_W-1:0] mrd,
    input  logic [SP_W-1:0] mod,
    output logic            col_ok,
    output logic            mrs_ok
);
    logic            col_seen;
    logic            mrs_seen;
    logic [SP_W-1:0] since_col;
    logic [SP_W-1:0] since_mrs;
    logic [BG_W-1:0] last_bg;
    logic [SP_W-1:0] need_col;

    // Choose the column gap from bank-group locality.
    assign need_col = (req_bg == last_bg) ? ccd_l : ccd_s;

    // Evaluate whether each command class has waited long enough.
    always_comb begin
        col_ok = (!col_seen || since_col >= need_col) &&
                 (!mrs_seen || since_mrs >= mod);
        mrs_ok = !mrs_seen || since_mrs >= mrd;
    end

    // Count cycles since the last column command and remember its group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_seen  <= 1'b0;
            since_col <= '0;
            last_bg   <= '0;
        end else if (col_fire) begin
            col_seen  <= 1'b1;
            since_col <= SP_W'(1);
            last_bg   <= req_bg;
        end else if (col_seen && since_col != '1) begin
            since_col <= since_col + 1'b1;
        end
    end

    // Count cycles since the last MRS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrs_seen  <= 1'b0;
            since_mrs <= '0;
        end else if (mrs_fire) begin
            mrs_seen  <= 1'b1;
            since_mrs <= SP_W'(1);
        end else if (mrs_seen && since_mrs != '1) begin
            since_mrs <= since_mrs + 1'b1;
        end
    end

    p_gap_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_fire && col_seen && req_bg != last_bg) |-> (since_col >= ccd_s));
    p_gap_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_fire && col_seen && req_bg == last_bg) |-> (since_col >= ccd_l));
    p_mrs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_fire && mrs_seen) |-> (since_mrs >= mrd));
    p_mrs_to_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_fire && mrs_seen) |-> (since_mrs >= mod));
    p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_fire && mrs_fire));
endmodule

// File: rtl/col_cmd_timer.sv
// Module: col_cmd_timer
// Gates READ, WRITE and MRS requests against the column and mode
// register spacing rules and schedules the read-valid and write-enable
// windows from the programmed latencies. Assumes the requester holds a
// request until it sees grant, and that CL and CWL are at least 1.
module col_cmd_timer #(
    parameter int BG_W  = 2,
    parameter int LAT_W = 5,
    parameter int SP_W  = 5,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [BG_W-1:0]  req_bg,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_cwl,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic [SP_W-1:0]  cfg_ccd_s,
    input  logic [SP_W-1:0]  cfg_ccd_l,
    input  logic [SP_W-1:0]  cfg_mrd,
    input  logic [SP_W-1:0]  cfg_mod,
    output logic             grant,
    output logic             rd_valid,
    output logic             wr_en
);
    import cct_pkg::*;

    localparam int LW    = LAT_W + 1;
    localparam int DEPTH = 2 * ((1 << LAT_W) - 1) + BURST;
    localparam int CFG_W = 3 * LAT_W + 4 * SP_W;

    logic             is_rd, is_wr, is_mrs;
    logic             col_ok, mrs_ok;
    logic             rd_fire, wr_fire, col_fire, mrs_fire;
    logic             rd_busy, wr_busy, hold;
    logic [CFG_W-1:0] act;
    logic [LAT_W-1:0] a_cl, a_cwl, a_al;
    logic [SP_W-1:0]  a_ccd_s, a_ccd_l, a_mrd, a_mod;
    logic [LW-1:0]    rl, wl;

    // Decode the presented command.
    always_comb begin
        is_rd  = req_valid && (req_kind == CMD_RD);
        is_wr  = req_valid && (req_kind == CMD_WR);
        is_mrs = req_valid && (req_kind == CMD_MRS);
    end

    // Accept a command when its spacing rules are met.
    always_comb begin
        rd_fire  = is_rd && col_ok;
        wr_fire  = is_wr && col_ok;
        col_fire = rd_fire || wr_fire;
        mrs_fire = is_mrs && mrs_ok;
        grant    = col_fire || mrs_fire;
    end

    assign hold = rd_busy || wr_busy || col_fire;

    cct_cfg_hold #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .cfg_i ({cfg_cl, cfg_cwl, cfg_al, cfg_ccd_s, cfg_ccd_l, cfg_mrd, cfg_mod}),
        .act_o (act)
    );

    assign {a_cl, a_cwl, a_al, a_ccd_s, a_ccd_l, a_mrd, a_mod} = act;

    // Total latencies from the active settings.
    always_comb begin
        rl = {1'b0, a_cl}  + {1'b0, a_al};
        wl = {1'b0, a_cwl} + {1'b0, a_al};
    end

    cct_spacing #(.BG_W(BG_W), .SP_W(SP_W)) u_space (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_fire (col_fire),
        .mrs_fire (mrs_fire),
        .req_bg   (req_bg),
        .ccd_s    (a_ccd_s),
        .ccd_l    (a_ccd_l),
        .mrd      (a_mrd),
        .mod      (a_mod),
        .col_ok   (col_ok),
        .mrs_ok   (mrs_ok)
    );

    cct_lat_line #(.LW(LW), .BURST(BURST), .DEPTH(DEPTH)) u_rd_line (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (rd_fire),
        .lat   (rl),
        .win   (rd_valid),
        .busy  (rd_busy)
    );

    cct_lat_line #(.LW(LW), .BURST(BURST), .DEPTH(DEPTH)) u_wr_line (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (wr_fire),
        .lat   (wl),
        .win   (wr_en),
        .busy  (wr_busy)
    );

    p_grant_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req_valid);
    p_des_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == CMD_DES) |-> !grant);
endmodule

// File: tb/sim_col_cmd_timer.sv
`timescale 1ns/100ps
module sim_col_cmd_timer;
    localparam int BG_W = 2, LAT_W = 5, SP_W = 5, BURST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [BG_W-1:0] req_bg = '0;
    logic [LAT_W-1:0] cfg_cl = 5, cfg_cwl = 4, cfg_al = 2;
    logic [SP_W-1:0] cfg_ccd_s = 5, cfg_ccd_l = 7, cfg_mrd = 4, cfg_mod = 6;
    logic grant, rd_valid, wr_en;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int rd_q[$];
    int wr_q[$];
    logic prev_rd = 1'b0, prev_wr = 1'b0;
    int run_rd = 0, run_wr = 0;

    always #2.5 clk = ~clk;

    col_cmd_timer #(.BG_W(BG_W), .LAT_W(LAT_W), .SP_W(SP_W), .BURST(BURST)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_bg(req_bg), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_al(cfg_al),
        .cfg_ccd_s(cfg_ccd_s), .cfg_ccd_l(cfg_ccd_l), .cfg_mrd(cfg_mrd),
        .cfg_mod(cfg_mod), .grant(grant), .rd_valid(rd_valid), .wr_en(wr_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present a command and hold it until granted; returns the grant cycle.
    task automatic issue(input logic [1:0] kind, input logic [BG_W-1:0] bg, output int n);
        req_valid = 1'b1;
        req_kind  = kind;
        req_bg    = bg;
        forever begin
            @(negedge clk);
            if (grant) begin
                n = cyc;
                break;
            end
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_kind  = 2'b00;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    // Monitor: pop expected window starts and compare start cycle and length.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid && !prev_rd) begin
                if (rd_q.size() == 0) chk(1'b0, "R1 unexpected read window", cyc, -1);
                else begin
                    int e;
                    e = rd_q.pop_front();
                    chk(cyc == e, "R1 read window start", cyc, e);
                end
                run_rd = 0;
            end
            if (!rd_valid && prev_rd) chk(run_rd == BURST, "R1 read window length", run_rd, BURST);
            if (rd_valid) run_rd++;
            if (wr_en && !prev_wr) begin
                if (wr_q.size() == 0) chk(1'b0, "R2 unexpected write window", cyc, -1);
                else begin
                    int e;
                    e = wr_q.pop_front();
                    chk(cyc == e, "R2 write window start", cyc, e);
                end
                run_wr = 0;
            end
            if (!wr_en && prev_wr) chk(run_wr == BURST, "R2 write window length", run_wr, BURST);
            if (wr_en) run_wr++;
            prev_rd = rd_valid;
            prev_wr = wr_en;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0, n1, t0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(grant == 1'b0, "R9 grant idle after reset", grant, 0);
        chk(rd_valid == 1'b0, "R9 rd_valid after reset", rd_valid, 0);
        chk(wr_en == 1'b0, "R9 wr_en after reset", wr_en, 0);
        @(posedge clk); #1;

        // First read unconstrained; RL = 5 + 2.
        t0 = cyc;
        issue(2'b01, 2'd0, n0);
        chk(n0 == t0, "R9 first read not held", n0, t0);
        rd_q.push_back(n0 + 7);
        // Different group: short gap.
        issue(2'b01, 2'd1, n1);
        chk(n1 - n0 == 5, "R3 cross-group gap", n1 - n0, 5);
        chk(n1 - n0 > 1, "R7 held read later granted", n1 - n0, 5);
        rd_q.push_back(n1 + 7);
        n0 = n1;
        // Same group: long gap.
        issue(2'b01, 2'd1, n1);
        chk(n1 - n0 == 7, "R4 same-group read gap", n1 - n0, 7);
        rd_q.push_back(n1 + 7);
        n0 = n1;
        // Write to same group: long gap; WL = 4 + 2.
        issue(2'b10, 2'd1, n1);
        chk(n1 - n0 == 7, "R4 read-to-write same group gap", n1 - n0, 7);
        wr_q.push_back(n1 + 6);
        n0 = n1;
        issue(2'b10, 2'd2, n1);
        chk(n1 - n0 == 5, "R3 write cross-group gap", n1 - n0, 5);
        wr_q.push_back(n1 + 6);
        idle(30);

        // MRS spacing.
        issue(2'b11, 2'd0, n0);
        issue(2'b11, 2'd0, n1);
        chk(n1 - n0 == 4, "R5 MRS to MRS gap", n1 - n0, 4);
        n0 = n1;
        issue(2'b01, 2'd3, n1);
        chk(n1 - n0 == 6, "R6 MRS to read gap", n1 - n0, 6);
        rd_q.push_back(n1 + 7);
        n0 = n1;
        issue(2'b11, 2'd0, n1);
        chk(n1 - n0 == 1, "R5 MRS not held by column gap", n1 - n0, 1);
        idle(30);

        // Deselect is never granted.
        req_valid = 1'b1;
        req_kind  = 2'b00;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(grant == 1'b0, "R10 deselect not granted", grant, 0);
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
        idle(2);

        // Config change while a read is pending.
        issue(2'b01, 2'd0, n0);
        rd_q.push_back(n0 + 7);
        cfg_cl = 9;
        idle(30);
        issue(2'b01, 2'd0, n1);
        chk(n1 > n0, "R8 read after config change granted", n1, n0);
        rd_q.push_back(n1 + 11);
        idle(30);

        // Additive latency zero.
        cfg_al = 0;
        idle(3);
        issue(2'b01, 2'd2, n0);
        rd_q.push_back(n0 + 9);
        idle(2);
        issue(2'b10, 2'd1, n1);
        chk(n1 - n0 == 5, "R3 cross-group gap with AL zero", n1 - n0, 5);
        wr_q.push_back(n1 + 4);
        idle(30);

        chk(rd_q.size() == 0, "R1 all read windows seen", rd_q.size(), 0);
        chk(wr_q.size() == 0, "R2 all write windows seen", wr_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule